// File: doc/BRIEF.md
# I2C Register-Access Master

This block is a single-master controller for a two-wire serial bus. It carries out one register-addressed transfer per command to a slave with a 7-bit address. A write sends a start condition, the slave address with the direction bit at 0, a register index and one data byte, and then a stop. A read sends the address with the direction bit at 0 and the register index. It then issues a repeated start with no stop in between, sends the address again with the direction bit at 1, and takes in one byte. The controller answers that byte with a not-acknowledge and ends with a stop.

The host sets the address, register index, write data and direction, and then pulses a start input for one cycle. The block reports busy while a transfer runs. At the end it gives a one-cycle done pulse, the byte it read, and an error flag that shows whether the slave failed to acknowledge an address byte or the register byte. Both bus lines are open-drain. The block never drives a line high. It only asserts an output enable that pulls the line low, and a released line reads high through the external pull-up. A divider splits each bit time into four equal quarters of the system clock, and these quarters set the clock and data timing.

Top module: `i2cm_reg_master`

## Requirements
- R1: While reset is high and in the first cycle after it, scl_oe, sda_oe, busy, done and ack_err are all 0 and rd_data is 0x00.
- R2: While SCL is high, SDA changes only as part of a start, repeated-start or stop condition. A start or repeated start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high.
- R3: A write (cmd_read=0) puts one start on the bus and then three bytes, each most-significant bit first and each followed by an acknowledge slot. The bytes are {cmd_addr, 1'b0}, cmd_reg and cmd_wdata. The write then ends with one stop.
- R4: A read (cmd_read=1) sends {cmd_addr, 1'b0} and cmd_reg, then a repeated start, then {cmd_addr, 1'b1}. It shifts in one byte MSB first, sampling SDA while SCL is high, and leaves SDA released (NACK) in that byte's acknowledge slot. It then sends one stop, and rd_data holds the received byte once done pulses.
- R5: If SDA reads high in the acknowledge slot after an address byte or after the register byte, ack_err goes to 1. No further byte is sent, and a stop ends the transfer.
- R6: busy goes to 1 in the cycle after an accepted cmd_start. done is a single-cycle pulse, and busy is already 0 in the cycle where done is 1.
- R7: cmd_start is ignored while busy is 1. The transfer in progress keeps the command it accepted, and no second transfer follows.
- R8: Each bit lasts 4*QTR_CYCLES clocks, with SCL released high for 2*QTR_CYCLES clocks and pulled low for 2*QTR_CYCLES clocks between bits.
- R9: ack_err holds its value until the next accepted cmd_start, which clears it.
- R10: Whenever busy is 0, both scl_oe and sda_oe are 0, so the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_start | input | 1 | One-cycle request that starts a transfer |
| cmd_read | input | 1 | 1 selects a register read, 0 selects a register write |
| cmd_addr | input | 7 | Slave address |
| cmd_reg | input | 8 | Register index sent after the address |
| cmd_wdata | input | 8 | Data byte for a write |
| sda_i | input | 1 | Level of the SDA line as seen at the pin |
| scl_oe | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rd_data | output | 8 | Byte received by the last successful read |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse at the end of a transfer |
| ack_err | output | 1 | A slave did not acknowledge an address or register byte |

## Verification
The embedded properties check the following on every cycle:
- SDA holds steady through each high phase of SCL inside data and acknowledge bits.
- The bus is released whenever the controller is idle.
- done is a lone pulse that coincides with busy falling.
- The latched command does not move during a transfer.
- The quarter divider counts down evenly.

Only the bench scenarios show the bus contents themselves. The bench uses a behavioural slave on a wired-AND bus to observe:
- the byte order and the direction bits;
- the repeated start inside a read;
- the master's final not-acknowledge;
- the data value returned in rd_data;
- the early stop after a refused address or register byte;
- the exact SCL high and low times.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    localparam int BYTE_BITS = 8;
    localparam int SLOT_LAST = BYTE_BITS;   // index of the acknowledge slot

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_START,
        ST_ADDR_W,
        ST_REG,
        ST_WDATA,
        ST_RSTART,
        ST_ADDR_R,
        ST_RDATA,
        ST_STOP
    } seq_e;

    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
        logic [7:0] idx;
        logic [7:0] wdata;
    } cmd_t;

    typedef struct packed {
        logic scl;   // 1 = released (high)
        logic sda;   // 1 = released (high)
    } lines_t;

    // Symbols that deliberately move SDA while SCL is high (or idle bus)
    function automatic logic is_cond(input seq_e st);
        return (st == ST_IDLE) || (st == ST_START) ||
               (st == ST_RSTART) || (st == ST_STOP);
    endfunction

    // Acknowledge slots whose NACK aborts the transfer
    function automatic logic ack_checked(input seq_e st);
        return (st == ST_ADDR_W) || (st == ST_REG) || (st == ST_ADDR_R);
    endfunction

    // Line levels for each quarter of the current symbol
    function automatic lines_t line_levels(input seq_e st, input logic [1:0] q,
                                           input logic bitval);
        lines_t l;
        case (st)
            ST_IDLE: begin
                l.scl = 1'b1;
                l.sda = 1'b1;
            end
            ST_START: begin
                l.scl = (q != 2'd3);
                l.sda = (q < 2'd2);
            end
            ST_RSTART: begin
                l.scl = (q == 2'd1) || (q == 2'd2);
                l.sda = (q < 2'd2);
            end
            ST_STOP: begin
                l.scl = (q != 2'd0);
                l.sda = (q >= 2'd2);
            end
            default: begin
                l.scl = (q == 2'd1) || (q == 2'd2);
                l.sda = bitval;
            end
        endcase
        return l;
    endfunction

endpackage

// File: rtl/i2cm_qtr_timer.sv
module i2cm_qtr_timer #(
    parameter int QTR_CYCLES = 125
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= RELOAD;
        end else if (cnt == '0) begin
            cnt <= RELOAD;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    assign tick = run && (cnt == '0);

    // R8: quarters are of equal length -> counter steps down by one while running
    a_r8_even_quarters: assert property (@(posedge clk) disable iff (rst)
        (run && cnt != '0) |=> (!run || cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/i2cm_sync.sv
module i2cm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b1;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       sda_in,
    input  logic       cmd_start,
    input  cmd_t       cmd_in,
    output logic       busy,
    output lines_t     lines_q,
    output logic [7:0] rd_data,
    output logic       done,
    output logic       ack_err
);
    seq_e       st;
    logic [1:0] q;
    logic [3:0] bitcnt;
    logic [7:0] txsh;
    logic [7:0] rxsh;
    logic       samp;
    cmd_t       cmd_q;
    logic       cond_q;
    logic       bitval;
    logic       sym_end;
    logic       in_ack;

    assign busy    = (st != ST_IDLE);
    assign in_ack  = (bitcnt == 4'(SLOT_LAST));
    assign bitval  = (st == ST_RDATA) || in_ack || txsh[7];
    assign sym_end = tick && (q == 2'd3);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            q       <= 2'd0;
            bitcnt  <= 4'd0;
            txsh    <= 8'h00;
            rxsh    <= 8'h00;
            samp    <= 1'b1;
            cmd_q   <= '0;
            rd_data <= 8'h00;
            done    <= 1'b0;
            ack_err <= 1'b0;
            lines_q <= '{scl: 1'b1, sda: 1'b1};
            cond_q  <= 1'b1;
        end else begin
            done    <= 1'b0;
            lines_q <= line_levels(st, q, bitval);
            cond_q  <= is_cond(st);

            if (st == ST_IDLE && cmd_start) begin
                cmd_q   <= cmd_in;
                st      <= ST_START;
                q       <= 2'd0;
                bitcnt  <= 4'd0;
                ack_err <= 1'b0;
            end

            if (tick) begin
                q <= q + 2'd1;
                if (q == 2'd1) samp <= sda_in;
            end

            if (sym_end) begin
                case (st)
                    ST_START: begin
                        st     <= ST_ADDR_W;
                        txsh   <= {cmd_q.addr, 1'b0};
                        bitcnt <= 4'd0;
                    end
                    ST_RSTART: begin
                        st     <= ST_ADDR_R;
                        txsh   <= {cmd_q.addr, 1'b1};
                        bitcnt <= 4'd0;
                    end
                    ST_ADDR_W, ST_REG, ST_WDATA, ST_ADDR_R: begin
                        if (!in_ack) begin
                            txsh   <= {txsh[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end else begin
                            bitcnt <= 4'd0;
                            if (samp && ack_checked(st)) begin
                                ack_err <= 1'b1;
                                st      <= ST_STOP;
                            end else begin
                                case (st)
                                    ST_ADDR_W: begin
                                        st   <= ST_REG;
                                        txsh <= cmd_q.idx;
                                    end
                                    ST_REG: begin
                                        if (cmd_q.rd) begin
                                            st <= ST_RSTART;
                                        end else begin
                                            st   <= ST_WDATA;
                                            txsh <= cmd_q.wdata;
                                        end
                                    end
                                    ST_ADDR_R: st <= ST_RDATA;
                                    default:   st <= ST_STOP;
                                endcase
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (!in_ack) begin
                            rxsh   <= {rxsh[6:0], samp};
                            bitcnt <= bitcnt + 4'd1;
                        end else begin
                            rd_data <= rxsh;
                            bitcnt  <= 4'd0;
                            st      <= ST_STOP;
                        end
                    end
                    ST_STOP: begin
                        st   <= ST_IDLE;
                        done <= 1'b1;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    // R2: inside data/ack bits SDA is frozen while SCL stays high
    a_r2_sda_stable_scl_high: assert property (@(posedge clk) disable iff (rst)
        (lines_q.scl && $past(lines_q.scl) && !cond_q && !$past(cond_q))
            |-> $stable(lines_q.sda));

    // R6: done lasts one cycle and coincides with the return to idle
    a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    a_r6_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R7: the accepted command does not change during a transfer
    a_r7_cmd_held: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd_q));

    // R5: an abort never happens outside an acknowledge slot of a checked byte
    a_r5_err_from_ack: assert property (@(posedge clk) disable iff (rst)
        $rose(ack_err) |-> (st == ST_STOP && $past(ack_checked(st))));

endmodule

// File: rtl/i2cm_reg_master.sv
module i2cm_reg_master
    import i2cm_pkg::*;
#(
    parameter int QTR_CYCLES  = 125,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_start,
    input  logic       cmd_read,
    input  logic [6:0] cmd_addr,
    input  logic [7:0] cmd_reg,
    input  logic [7:0] cmd_wdata,
    input  logic       sda_i,
    output logic       scl_oe,
    output logic       sda_oe,
    output logic [7:0] rd_data,
    output logic       busy,
    output logic       done,
    output logic       ack_err
);
    logic   tick;
    logic   sda_s;
    lines_t lines;
    cmd_t   cmd;

    assign cmd = '{rd: cmd_read, addr: cmd_addr, idx: cmd_reg, wdata: cmd_wdata};

    i2cm_qtr_timer #(.QTR_CYCLES(QTR_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    i2cm_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sda_i),
        .q   (sda_s)
    );

    i2cm_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .sda_in    (sda_s),
        .cmd_start (cmd_start),
        .cmd_in    (cmd),
        .busy      (busy),
        .lines_q   (lines),
        .rd_data   (rd_data),
        .done      (done),
        .ack_err   (ack_err)
    );

    assign scl_oe = ~lines.scl;
    assign sda_oe = ~lines.sda;

    // R10: idle controller leaves both lines released
    a_r10_idle_released: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!scl_oe && !sda_oe));

endmodule

// File: tb/sim_i2cm_reg_master.sv
`timescale 1ns/1ps
module sim_i2cm_reg_master;

    localparam int QTR   = 4;
    localparam int WD_LIM = 150000;
    localparam logic [6:0] SADDR = 7'b1011001;

    typedef struct packed {
        logic       rd;
        logic [6:0] addr;
        logic [7:0] idx;
        logic [7:0] wdata;
        logic [7:0] rdval;
        logic [1:0] nack_at;   // 1 = slave refuses register byte, 3 = none
        logic       exp_err;
        logic [7:0] exp_rd;
        logic [2:0] exp_bytes;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 7'h59, 8'h10, 8'h00, 8'h5D, 2'd3, 1'b0, 8'h5D, 3'd4},
        '{1'b0, 7'h59, 8'h22, 8'hA5, 8'h00, 2'd3, 1'b0, 8'h00, 3'd3},
        '{1'b1, 7'h59, 8'h80, 8'h00, 8'h01, 2'd3, 1'b0, 8'h01, 3'd4},
        '{1'b0, 7'h59, 8'hFF, 8'h00, 8'h00, 2'd3, 1'b0, 8'h00, 3'd3},
        '{1'b0, 7'h12, 8'h33, 8'h44, 8'h00, 2'd3, 1'b1, 8'h00, 3'd1},
        '{1'b1, 7'h59, 8'h05, 8'h00, 8'h77, 2'd1, 1'b1, 8'h00, 3'd2},
        '{1'b1, 7'h58, 8'h06, 8'h00, 8'h77, 2'd3, 1'b1, 8'h00, 3'd1},
        '{1'b1, 7'h59, 8'h7E, 8'h00, 8'hFF, 2'd3, 1'b0, 8'hFF, 3'd4},
        '{1'b1, 7'h59, 8'h01, 8'h00, 8'h00, 2'd3, 1'b0, 8'h00, 3'd4},
        '{1'b0, 7'h59, 8'h44, 8'h99, 8'h00, 2'd1, 1'b1, 8'h00, 3'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_start = 1'b0;
    logic       cmd_read = 1'b0;
    logic [6:0] cmd_addr = 7'h00;
    logic [7:0] cmd_reg = 8'h00;
    logic [7:0] cmd_wdata = 8'h00;
    logic       scl_oe, sda_oe, busy, done, ack_err;
    logic [7:0] rd_data;

    // wired-AND bus with pull-ups
    logic s_drv = 1'b0;
    logic scl_line, sda_line;
    assign scl_line = ~scl_oe;
    assign sda_line = ~(sda_oe | s_drv);

    always #2.5 clk = ~clk;

    i2cm_reg_master #(.QTR_CYCLES(QTR), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_start (cmd_start),
        .cmd_read  (cmd_read),
        .cmd_addr  (cmd_addr),
        .cmd_reg   (cmd_reg),
        .cmd_wdata (cmd_wdata),
        .sda_i     (sda_line),
        .scl_oe    (scl_oe),
        .sda_oe    (sda_oe),
        .rd_data   (rd_data),
        .busy      (busy),
        .done      (done),
        .ack_err   (ack_err)
    );

    // ---------------- behavioural slave ----------------
    logic [7:0] rdval   = 8'h00;
    logic [1:0] nack_at = 2'd3;
    int   starts = 0, stops = 0, bytes = 0;
    logic [7:0] reg_cap = 8'h00, wd_cap = 8'h00, addr_cap = 8'h00;
    logic       m_ack = 1'b0;
    logic p_scl = 1'b1, p_sda = 1'b1;
    logic skip = 1'b0, tx = 1'b0, txpend = 1'b0, addr_ph = 1'b0, match = 1'b0;
    logic [7:0] sh = 8'h00;
    int   bitcnt = 0, bidx = 0;
    logic in_txn = 1'b0;

    always @(negedge clk) begin
        if (scl_line && p_scl && p_sda && !sda_line) begin
            starts++;
            skip = 1'b1; bitcnt = 0; s_drv = 1'b0; tx = 1'b0; txpend = 1'b0;
            addr_ph = 1'b1;
            if (!in_txn) bidx = 0;
            in_txn = 1'b1;
        end else if (scl_line && p_scl && !p_sda && sda_line) begin
            stops++;
            in_txn = 1'b0; s_drv = 1'b0; tx = 1'b0;
        end else if (scl_line && !p_scl) begin
            if (bitcnt < 8 && !tx) sh = {sh[6:0], sda_line};
            if (bitcnt == 8 && tx) m_ack = sda_line;
        end else if (!scl_line && p_scl) begin
            if (skip) begin
                skip = 1'b0;
            end else if (bitcnt == 8) begin
                bitcnt = 0; bidx++; s_drv = 1'b0;
                if (txpend) begin tx = 1'b1; txpend = 1'b0; end
                else if (tx && m_ack) tx = 1'b0;
                if (tx) s_drv = !rdval[7];
            end else begin
                bitcnt++;
                if (tx && bitcnt < 8) s_drv = !rdval[7 - bitcnt];
                if (bitcnt == 8) begin
                    bytes++;
                    if (tx) begin
                        s_drv = 1'b0;
                    end else begin
                        if (addr_ph) begin
                            addr_cap = sh;
                            match = (sh[7:1] == SADDR);
                            if (sh[7:1] == SADDR && sh[0]) txpend = 1'b1;
                            addr_ph = 1'b0;
                        end else if (bidx == 1) begin
                            reg_cap = sh;
                        end else begin
                            wd_cap = sh;
                        end
                        s_drv = match && (bidx != int'(nack_at));
                    end
                end
            end
        end
        p_scl = scl_line;
        p_sda = sda_line;
    end

    // ---------------- checking ----------------
    int n_chk = 0, n_fail = 0, cyc = 0;
    logic finished = 1'b0;

    always @(posedge clk) cyc++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic issue(input logic rd, input logic [6:0] a, input logic [7:0] r,
                         input logic [7:0] w);
        @(negedge clk);
        cmd_read = rd; cmd_addr = a; cmd_reg = r; cmd_wdata = w;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done && cyc < WD_LIM) @(negedge clk);
    endtask

    initial begin
        wait (cyc >= WD_LIM);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int s0, p0, b0, n;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 scl_oe", scl_oe, 0);
        chk("R1 sda_oe", sda_oe, 0);
        chk("R1 busy", busy, 0);
        chk("R1 ack_err", ack_err, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 done", done, 0);
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R10 idle bus", {scl_oe, sda_oe}, 0);

        // vector walk: R3 writes, R4 reads, R5 refusals
        for (int i = 0; i < NV; i++) begin
            rdval = VECS[i].rdval;
            nack_at = VECS[i].nack_at;
            s0 = starts; p0 = stops; b0 = bytes;
            issue(VECS[i].rd, VECS[i].addr, VECS[i].idx, VECS[i].wdata);
            chk("R6 busy after start", busy, 1);
            wait_done();
            chk("R6 busy low at done", busy, 0);
            chk("R5 ack_err", ack_err, VECS[i].exp_err);
            chk("R5 bytes on bus", bytes - b0, VECS[i].exp_bytes);
            chk("R3 one stop", stops - p0, 1);
            if (!VECS[i].exp_err && !VECS[i].rd) begin
                chk("R3 addr byte", addr_cap, {VECS[i].addr, 1'b0});
                chk("R3 reg byte", reg_cap, VECS[i].idx);
                chk("R3 data byte", wd_cap, VECS[i].wdata);
                chk("R3 single start", starts - s0, 1);
            end
            if (!VECS[i].exp_err && VECS[i].rd) begin
                chk("R4 rd_data", rd_data, VECS[i].exp_rd);
                chk("R4 reg byte", reg_cap, VECS[i].idx);
                chk("R4 read addr byte", addr_cap, {VECS[i].addr, 1'b1});
                chk("R4 repeated start", starts - s0, 2);
                chk("R4 master NACK", m_ack, 1);
            end
            @(negedge clk);
            chk("R6 done single pulse", done, 0);
            chk("R10 released after transfer", {scl_oe, sda_oe}, 0);
        end

        // R9: error flag held while idle
        repeat (30) @(negedge clk);
        chk("R9 ack_err held", ack_err, 1);

        // R8: SCL high/low times; R9 cleared by accepted start
        rdval = 8'h00; nack_at = 2'd3;
        issue(1'b0, SADDR, 8'h3C, 8'h5A);
        chk("R9 ack_err cleared", ack_err, 0);
        while (scl_line) @(negedge clk);
        while (!scl_line) @(negedge clk);
        n = 0;
        while (scl_line) begin n++; @(negedge clk); end
        chk("R8 scl high time", n, 2 * QTR);
        n = 0;
        while (!scl_line) begin n++; @(negedge clk); end
        chk("R8 scl low time", n, 2 * QTR);
        wait_done();
        chk("R8 transfer ok", ack_err, 0);

        // R7: start while busy is ignored
        s0 = starts;
        issue(1'b0, SADDR, 8'h31, 8'h6C);
        repeat (40) @(negedge clk);
        issue(1'b1, SADDR, 8'h99, 8'h00);
        wait_done();
        repeat (40) @(negedge clk);
        chk("R7 busy stays low", busy, 0);
        chk("R7 single transfer", starts - s0, 1);
        chk("R7 reg kept", reg_cap, 8'h31);
        chk("R7 data kept", wd_cap, 8'h6C);

        finish_run();
    end

endmodule